// File: doc/BRIEF.md
# Glitch-free two-input clock switch

This block picks one of two free-running clocks and drives it onto a single output clock. The output is never cut short when the choice changes. Each input has three controls: an enable, a select, and a skip control. An input becomes a candidate only when its enable and its select are both High. When the candidate changes, the input that currently drives the output first lets go at its own falling edge. The output then stays Low until the new input has been picked up at one of its falling edges. The enable of each input passes through a small synchronizer that runs on the falling edge of that input's clock. Each input stays locked out for as long as the other input still holds the output, so at most one clock is ever gated through.

Three parameters set the start-up behaviour. `INIT_HIGH` sets the output level after reset, until the first clock is passed. `PRESEL_EN` and `PRESEL_IDX` let one input own the output straight out of reset. There are two ways to take the output away from a clock that has stopped, so that the old clock is not waited on. One is to raise that input's skip control. The other is to drive the switch with the enables alone while the selects are tied High.

Reset is synchronous and active-low. Each input domain samples it on its own falling edge, so both clocks must run while reset is held. Any change to an enable or a skip control on the input that owns the output must be made while that input's clock is Low.

Top module: `clk_switch_gf`

## Requirements
- R1: After reset, clk_out holds the level given by INIT_HIGH (1 = High, 0 = Low) until the first input is passed through.
- R2: Input k is a candidate when en_k and sel_k are both High. When both inputs are candidates, input 0 is taken. Once the handover has finished, clk_out is equal to the chosen input clock.
- R3: Every high phase and every low phase of clk_out lasts at least half the period of the faster input. The two inputs are never gated through at the same time.
- R4: A switch made through sel waits for a falling edge of the old clock. While that clock is stopped Low and its skip control is Low, clk_out stays Low and does not follow the new clock.
- R5: While skip_k is High, taking input k out of the selection releases it at once. The output then moves to the new clock even when clock k is stopped.
- R6: When the selects are tied High, dropping en_k releases input k at once without waiting for clock k. The output then moves to the new clock even when clock k is stopped.
- R7: Once an input has been passed through, clk_out stays Low with no pulses whenever neither input is a candidate.
- R8: With PRESEL_EN = 1, input PRESEL_IDX owns the output from reset. While it remains a candidate, clk_out follows it from the first falling edge of that clock after reset is released, without the two-edge synchronizer delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in0 | input | 1 | First input clock |
| clk_in1 | input | 1 | Second input clock |
| rst_n | input | 1 | Active-low reset, sampled on each input clock's falling edge |
| en0 | input | 1 | Enable qualifier for clk_in0 |
| sel0 | input | 1 | Select qualifier for clk_in0 |
| skip0 | input | 1 | Skip the wait on clk_in0 when it is released |
| en1 | input | 1 | Enable qualifier for clk_in1 |
| sel1 | input | 1 | Select qualifier for clk_in1 |
| skip1 | input | 1 | Skip the wait on clk_in1 when it is released |
| clk_out | output | 1 | Switched output clock |

## Verification
The hardest situation to reach is a handover away from a clock that has stopped. A stopped clock produces no falling edge, so the normal handshake can never finish. Only the skip control or the enable-only path can release it.

The bench has gated clock generators. Each generator finishes its current high phase and then parks Low. With the old clock parked, the bench makes the switch three ways: through sel alone, which must stay parked; with skip raised; and with the enable alone. It then restarts the parked clock so that the stale owner clears before skip is lowered again.

A phase monitor times every output edge the whole time. Constrained-random select sequences then mix handovers that arrive at arbitrary phase offsets between the two unrelated input periods.

// File: rtl/ckmux_pkg.sv
// Package: shared types and sizes for the glitch-free clock switch.
// Assumes exactly two input lanes; the lane count is kept here so that
// the picker, the lanes and the output stage agree on one value.
package ckmux_pkg;

    localparam int unsigned NUM_LANES = 2;

    // Per-lane qualifiers as seen at the block edge.
    typedef struct packed {
        logic en;
        logic sel;
        logic skip;
    } lane_ctl_t;

endpackage

// File: rtl/ckmux_pick.sv
// Module: ckmux_pick
// Turns the raw per-lane qualifiers into a one-hot (or empty) choice.
// A lane qualifies when both its enable and its select are High; the
// lowest-numbered qualifying lane wins. Purely combinational and not
// synchronized: each lane resynchronizes its own request.
module ckmux_pick
    import ckmux_pkg::*;
(
    input  lane_ctl_t [NUM_LANES-1:0] ctl,
    output logic      [NUM_LANES-1:0] pick
);

    logic taken;

    // Priority scan: the first qualifying lane takes the output.
    always_comb begin
        taken = 1'b0;
        for (int i = 0; i < NUM_LANES; i++) begin
            pick[i] = ctl[i].en & ctl[i].sel & ~taken;
            taken   = taken | (ctl[i].en & ctl[i].sel);
        end
    end

endmodule

// File: rtl/ckmux_lane.sv
// Module: ckmux_lane
// One input lane of the clock switch. The lane requests ownership when it
// is picked and no other lane holds the output. The request passes through
// a SYNC_STAGES-deep chain clocked on the falling edge of the lane's own
// clock, so the gate only opens or closes while that clock is Low.
// 'held' covers the whole chain, so another lane stays locked out until
// this lane has fully let go. The release of an unpicked lane is forced at
// once (without waiting for its clock) when its skip control is High or
// its enable is Low; callers must make such changes while the clock is Low.
// 'seen' is sticky: it marks that this lane has been passed since reset.
// Assumes SYNC_STAGES >= 2 and that rst_n is held across a few clock edges.
module ckmux_lane #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter bit          PRESET      = 1'b0
) (
    input  logic clk_in,
    input  logic rst_n,
    input  logic en_in,
    input  logic skip_in,
    input  logic pick,
    input  logic other_held,
    output logic held,
    output logic gate,
    output logic seen
);

    localparam int unsigned LAST = SYNC_STAGES - 1;

    logic [LAST:0] stg;
    logic          req;
    logic          drop;

    // Request and forced-release terms.
    always_comb begin
        req  = pick & ~other_held;
        drop = ~pick & (skip_in | ~en_in);
    end

    // Falling-edge synchronizer chain and the sticky 'passed' flag.
    always_ff @(negedge clk_in) begin
        if (!rst_n) begin
            stg  <= {SYNC_STAGES{PRESET}};
            seen <= 1'b0;
        end else begin
            stg  <= {stg[LAST-1:0], req};
            seen <= seen | stg[LAST-1];
        end
    end

    // Ownership seen by the other lane, and the gate for this clock.
    always_comb begin
        held = (|stg) & ~drop;
        gate = stg[LAST] & ~drop;
    end

endmodule

// File: rtl/ckmux_drive.sv
// Module: ckmux_drive
// Output stage: AND-OR of every clock with its gate and its 'seen' flag,
// plus the reset level until some lane has been passed. Relies on the
// lanes changing gate and seen only while their clock is Low.
module ckmux_drive
    import ckmux_pkg::*;
#(
    parameter bit INIT_HIGH = 1'b0
) (
    input  logic [NUM_LANES-1:0] clk_vec,
    input  logic [NUM_LANES-1:0] gate,
    input  logic [NUM_LANES-1:0] seen,
    output logic                 clk_out
);

    // Combine the gated clocks with the start-up level.
    always_comb begin
        clk_out = (|(clk_vec & gate & seen)) | (INIT_HIGH & ~(|seen));
    end

endmodule

// File: rtl/clk_switch_gf.sv
// Module: clk_switch_gf (top)
// Glitch-free switch between two clocks. Each clock has an enable, a
// select and a skip control. A handover waits for the old clock to fall
// and then for the new clock to fall, so no runt phase reaches clk_out.
// Parameters set the output level after reset and an optional lane that
// owns the output from reset. Assumes both clocks run during reset and
// that en/skip changes on the owning lane are made while its clock is Low.
module clk_switch_gf
    import ckmux_pkg::*;
#(
    parameter bit          INIT_HIGH   = 1'b0,
    parameter int unsigned SYNC_STAGES = 2,
    parameter bit          PRESEL_EN   = 1'b0,
    parameter int unsigned PRESEL_IDX  = 0
) (
    input  logic clk_in0,
    input  logic clk_in1,
    input  logic rst_n,
    input  logic en0,
    input  logic sel0,
    input  logic skip0,
    input  logic en1,
    input  logic sel1,
    input  logic skip1,
    output logic clk_out
);

    lane_ctl_t [NUM_LANES-1:0] ctl;
    logic      [NUM_LANES-1:0] clk_vec;
    logic      [NUM_LANES-1:0] pick;
    logic      [NUM_LANES-1:0] held;
    logic      [NUM_LANES-1:0] others;
    logic      [NUM_LANES-1:0] gate;
    logic      [NUM_LANES-1:0] seen;

    // Gather the port-level controls into per-lane records.
    always_comb begin
        ctl[0]  = '{en: en0, sel: sel0, skip: skip0};
        ctl[1]  = '{en: en1, sel: sel1, skip: skip1};
        clk_vec = {clk_in1, clk_in0};
    end

    ckmux_pick u_pick (
        .ctl  (ctl),
        .pick (pick)
    );

    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
        localparam bit LANE_PRESET = PRESEL_EN && (PRESEL_IDX == i);

        // Lock-out term: any other lane still holding the output.
        always_comb begin
            others[i] = |(held & ~(NUM_LANES'(1) << i));
        end

        ckmux_lane #(
            .SYNC_STAGES (SYNC_STAGES),
            .PRESET      (LANE_PRESET)
        ) u_lane (
            .clk_in     (clk_vec[i]),
            .rst_n      (rst_n),
            .en_in      (ctl[i].en),
            .skip_in    (ctl[i].skip),
            .pick       (pick[i]),
            .other_held (others[i]),
            .held       (held[i]),
            .gate       (gate[i]),
            .seen       (seen[i])
        );
    end

    ckmux_drive #(
        .INIT_HIGH (INIT_HIGH)
    ) u_drive (
        .clk_vec (clk_vec),
        .gate    (gate),
        .seen    (seen),
        .clk_out (clk_out)
    );

endmodule

// File: rtl/ckmux_chk.sv
// Module: ckmux_chk
// Assertion checker bound to clk_switch_gf. It watches the per-lane gates
// and 'seen' flags against the input clocks and the output clock. Assumes
// the stimulus rules stated for the top (en/skip changes made while Low).
module ckmux_chk #(
    parameter bit INIT_HIGH = 1'b0
) (
    input logic       clk_in0,
    input logic       clk_in1,
    input logic       rst_n,
    input logic [1:0] gate,
    input logic [1:0] seen,
    input logic       clk_out
);

    // R3: a gate may only move while its own clock is Low.
    always @(gate[0]) begin
        p_gate0_low_r3: assert (clk_in0 == 1'b0)
            else $error("R3 gate0 moved while clk_in0 High");
    end

    always @(gate[1]) begin
        p_gate1_low_r3: assert (clk_in1 == 1'b0)
            else $error("R3 gate1 moved while clk_in1 High");
    end

    // R3: never two clocks gated through together.
    p_one_owner_a_r3: assert property (@(negedge clk_in0) disable iff (!rst_n)
        $onehot0(gate))
        else $error("R3 both lanes gated (clk_in0 view)");

    p_one_owner_b_r3: assert property (@(negedge clk_in1) disable iff (!rst_n)
        $onehot0(gate))
        else $error("R3 both lanes gated (clk_in1 view)");

    // R1: start-up level until any lane has been passed.
    p_init_level_a_r1: assert property (@(negedge clk_in0) disable iff (!rst_n)
        (seen == 2'b00) |-> (clk_out == INIT_HIGH))
        else $error("R1 start-up level wrong");

    p_init_level_b_r1: assert property (@(negedge clk_in1) disable iff (!rst_n)
        (seen == 2'b00) |-> (clk_out == INIT_HIGH))
        else $error("R1 start-up level wrong");

    // R2: an owning lane's high phase reaches the output.
    p_follow0_r2: assert property (@(negedge clk_in0) disable iff (!rst_n)
        (gate[0] && seen[0]) |-> clk_out)
        else $error("R2 output missed clk_in0 high phase");

    p_follow1_r2: assert property (@(negedge clk_in1) disable iff (!rst_n)
        (gate[1] && seen[1]) |-> clk_out)
        else $error("R2 output missed clk_in1 high phase");

    // R7: idle after start-up means Low.
    p_idle_low_r7: assert property (@(negedge clk_in1) disable iff (!rst_n)
        ((seen != 2'b00) && (gate == 2'b00)) |-> !clk_out)
        else $error("R7 output not Low while idle");

endmodule

bind clk_switch_gf ckmux_chk #(
    .INIT_HIGH (INIT_HIGH)
) u_chk (
    .clk_in0 (clk_in0),
    .clk_in1 (clk_in1),
    .rst_n   (rst_n),
    .gate    (gate),
    .seen    (seen),
    .clk_out (clk_out)
);

// File: tb/test_clk_switch_gf.sv
// Bench for clk_switch_gf: two gated input clocks with unrelated periods
// (10 and 14 units), a 125 MHz (8 unit) reference for pacing and the
// watchdog, directed corner cases and a seeded random select sequence.
module test_clk_switch_gf;

    localparam int HALF0    = 5;
    localparam int HALF1    = 7;
    localparam int MIN_PH   = 5;
    localparam int WD_LIMIT = 150000;

    logic clk = 1'b0;
    logic ck0 = 1'b0;
    logic ck1 = 1'b0;
    logic run0 = 1'b1;
    logic run1 = 1'b1;
    logic rst_n = 1'b0;
    logic en0 = 1'b0, sel0 = 1'b0, skip0 = 1'b0;
    logic en1 = 1'b0, sel1 = 1'b0, skip1 = 1'b0;
    logic out_m;
    logic out_p;

    int  n_chk = 0;
    int  n_bad = 0;
    int  edges_m = 0;
    int  wd = 0;
    bit  mon_on = 1'b0;
    time last_t = 0;

    always #4 clk = ~clk;

    // Gated generators: finish the high phase, then park Low.
    always begin
        #HALF0;
        if (run0 || ck0) ck0 = ~ck0;
    end

    always begin
        #HALF1;
        if (run1 || ck1) ck1 = ~ck1;
    end

    clk_switch_gf #(
        .INIT_HIGH (1'b1)
    ) i_clk_switch_gf (
        .clk_in0 (ck0), .clk_in1 (ck1), .rst_n (rst_n),
        .en0 (en0), .sel0 (sel0), .skip0 (skip0),
        .en1 (en1), .sel1 (sel1), .skip1 (skip1),
        .clk_out (out_m)
    );

    clk_switch_gf #(
        .INIT_HIGH  (1'b0),
        .PRESEL_EN  (1'b1),
        .PRESEL_IDX (1)
    ) i_clk_switch_gf_pre (
        .clk_in0 (ck0), .clk_in1 (ck1), .rst_n (rst_n),
        .en0 (1'b0), .sel0 (1'b0), .skip0 (1'b0),
        .en1 (1'b1), .sel1 (1'b1), .skip1 (1'b0),
        .clk_out (out_p)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_sel(bit e0, bit s0, bit e1, bit s1);
        if (e0 && s0) return 0;
        if (e1 && s1) return 1;
        return 2;
    endfunction

    // R3: time every phase of the main output.
    always @(out_m) begin
        time dur;
        dur = $time - last_t;
        edges_m++;
        if (mon_on)
            check(dur >= MIN_PH, "R3 short phase", int'(dur), MIN_PH);
        last_t = $time;
    end

    task automatic settle();
        repeat (30) @(posedge clk);
        #1;
    endtask

    task automatic follow(input int k, input bit pre, input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            if (k == 0) @(posedge ck0); else @(posedge ck1);
            #1;
            check((pre ? out_p : out_m) == 1'b1, tag, int'(pre ? out_p : out_m), 1);
            if (k == 0) @(negedge ck0); else @(negedge ck1);
            #1;
            check((pre ? out_p : out_m) == 1'b0, tag, int'(pre ? out_p : out_m), 0);
        end
    endtask

    task automatic quiet(input int n, input bit lvl, input string tag);
        int e;
        e = edges_m;
        repeat (n) @(posedge clk);
        #1;
        check(edges_m == e, {tag, " edges"}, edges_m - e, 0);
        check(out_m == lvl, {tag, " level"}, int'(out_m), int'(lvl));
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    always @(posedge clk) begin
        wd++;
        if (wd == WD_LIMIT) begin
            check(1'b0, "R2 watchdog expired", wd, WD_LIMIT);
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_c10c));
        repeat (10) @(posedge clk);
        #1;
        check(out_m == 1'b1, "R1 main level in reset", int'(out_m), 1);
        check(out_p == 1'b0, "R1 preselect level in reset", int'(out_p), 0);
        rst_n = 1'b1;
        check(out_p == 1'b0, "R1 preselect level at release", int'(out_p), 0);

        // R8: preselected lane passes from its first falling edge.
        @(negedge ck1);
        @(posedge ck1);
        #1;
        check(out_p == 1'b1, "R8 first high phase after release", int'(out_p), 1);
        follow(1, 1'b1, 4, "R8 preselect follows clk_in1");

        mon_on = 1'b1;
        quiet(20, 1'b1, "R1 main holds High before any pass");

        en0 = 1'b1; sel0 = 1'b1; en1 = 1'b1;
        settle();
        follow(0, 1'b0, 4, "R2 input 0 chosen");

        // R4: old clock parked Low, switch through sel must stall.
        run0 = 1'b0;
        repeat (4) @(posedge clk);
        sel0 = 1'b0; sel1 = 1'b1;
        quiet(30, 1'b0, "R4 parked Low");
        run0 = 1'b1;
        settle();
        follow(1, 1'b0, 4, "R2 after parked clock resumes");

        // R5: skip lets the output leave a stopped clock.
        sel1 = 1'b0; sel0 = 1'b1;
        settle();
        follow(0, 1'b0, 2, "R2 back to input 0");
        skip0 = 1'b1;
        run0 = 1'b0;
        repeat (4) @(posedge clk);
        sel0 = 1'b0; sel1 = 1'b1;
        settle();
        follow(1, 1'b0, 4, "R5 handover with skip");
        run0 = 1'b1;
        repeat (10) @(posedge clk);
        skip0 = 1'b0;
        settle();
        follow(1, 1'b0, 2, "R5 stays on input 1 after skip drops");

        // R6: enable-only switching with both selects High.
        sel0 = 1'b1; sel1 = 1'b1;
        settle();
        follow(exp_sel(en0, sel0, en1, sel1), 1'b0, 3, "R2 both chosen, input 0 wins");
        en1 = 1'b0;
        run0 = 1'b0;
        repeat (4) @(posedge clk);
        en0 = 1'b0; en1 = 1'b1;
        settle();
        follow(exp_sel(en0, sel0, en1, sel1), 1'b0, 4, "R6 enable-only handover");
        run0 = 1'b1;
        settle();

        // R7: nothing chosen after start-up.
        sel0 = 1'b0; sel1 = 1'b0;
        settle();
        quiet(40, 1'b0, "R7 idle Low");

        en0 = 1'b1; en1 = 1'b1; sel0 = 1'b1; sel1 = 1'b1;
        settle();
        follow(0, 1'b0, 4, "R2 both chosen from idle");

        // Seeded random select sequence at arbitrary phase offsets.
        for (int it = 0; it < 30; it++) begin
            bit s0, s1;
            int e;
            s0 = 1'($urandom_range(0, 1));
            s1 = 1'($urandom_range(0, 1));
            repeat ($urandom_range(1, 5)) @(posedge clk);
            #($urandom_range(0, 3));
            sel0 = s0; sel1 = s1;
            settle();
            e = exp_sel(en0, sel0, en1, sel1);
            if (e == 2) quiet(10, 1'b0, "R7 random idle");
            else        follow(e, 1'b0, 3, "R2 random choice");
        end

        mon_on = 1'b0;
        summary();
        $finish;
    end

endmodule